// File: doc/BRIEF.md
# Byte-Serial Scan Link for Job Loading and Result Readout

This block is a user data register that sits behind a boundary-scan tap controller. It moves work and results between a host and a hashing core. Both directions use one 13-bit scan word. Every data-register scan runs through capture, then shift, then update. Each strobe arrives as a one-cycle pulse in the block's clock domain and counts only while the user instruction is selected. TDI enters at the top of the register, and TDO is bit 0.

On a write, the host sends a job one byte per scan: 32 midstate bytes, then 12 data bytes, most significant byte first, and finally a zero trailer byte. A control bit in each word marks the first byte of a job. The receiver can therefore restart assembly whenever it sees a first-byte word.

On a read, each capture takes the next byte of the oldest queued result nonce. The byte is tagged with a valid flag and a thermometer position code, so the host can find the start of a nonce without any length framing. The hashing core pushes nonces into a four-entry queue.

Top module: `jtag_byte_link`

## Requirements
- R1: After reset, `tdo` is 0, `job_valid` is 0, `job_data` is all zeros and `push_ready` is 1.
- R2: A capture while the nonce queue is empty loads the all-zero word, so bit 12 (valid) reads 0. Each shift moves the register one place toward bit 0, with `tdi` entering at bit 12 and `tdo` showing bit 0, so a word leaves least significant bit first.
- R3: A capture while a nonce is queued loads a word with bit 12 = 1, bits 7:0 = the nonce byte, and bits 11:8 = the position code: 1111 for byte 0 (least significant), 0111 for byte 1, 0011 for byte 2 and 0001 for byte 3. Bytes are sent least significant first.
- R4: The capture that sends byte 3 removes the nonce from the queue. The next capture starts the following nonce at byte 0, or loads zero if the queue is empty.
- R5: The queue holds up to four nonces in push order. `push_ready` is 0 while four are held, and a push offered then is dropped.
- R6: On an update, bits 7:0 of the register are a job byte and bit 8 is the continuation flag. A word with bit 8 = 0 starts a job and stores its byte as job byte 0. Job byte k lands in `job_data[351-8k -: 8]`.
- R7: `job_valid` pulses for exactly one cycle, in the cycle after the update that stores job byte 43. Continuation bytes after that, including the trailer, leave `job_data` unchanged until the next start byte.
- R8: A start byte that arrives while a job is partly loaded restarts the load at byte 0.
- R9: Continuation bytes received when no job has been started since reset are ignored.
- R10: While `sel` is 0, the capture, shift and update strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the tap strobes are synchronous to it |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | The user instruction is selected in the tap |
| cap | input | 1 | Capture-DR strobe |
| shift | input | 1 | Shift-DR strobe; one bit per pulse |
| upd | input | 1 | Update-DR strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (bit 0 of the scan register) |
| push_valid | input | 1 | The hashing core offers a nonce |
| push_nonce | input | 32 | Offered nonce value |
| push_ready | output | 1 | The queue can accept a nonce |
| job_data | output | 352 | Assembled job: midstate then data bytes, byte 0 in the top bits |
| job_valid | output | 1 | One-cycle pulse when a full job has been assembled |

## Verification
Readout is tried with an empty queue, with a single nonce whose four bytes are all different, and with five pushes against a four-entry queue. These cases separate a wrong position code, a wrong byte order, a pop at the wrong capture and a drop at the wrong fill level. Job loading is tried with a clean 45-word job, with a job cut short by a fresh start byte, with stray continuation bytes before any start and after completion, and with scans while `sel` is low. These cases separate wrong pointer resets, a trailer that overwrites job data, and strobes that are not gated by `sel`.

// File: rtl/jbl_pkg.sv
package jbl_pkg;
    localparam int WORD_W = 13;
    localparam int BYTE_W = 8;
    localparam int NONCE_BYTES = 4;

    typedef enum logic [1:0] {
        RD_B0 = 2'd0,
        RD_B1 = 2'd1,
        RD_B2 = 2'd2,
        RD_B3 = 2'd3
    } rd_state_e;

    typedef enum logic [1:0] {
        LD_IDLE = 2'd0,
        LD_FILL = 2'd1,
        LD_DONE = 2'd2
    } ld_state_e;

    // Thermometer position code: all ones for byte 0, one fewer each byte.
    function automatic logic [3:0] pos_code(input logic [1:0] idx);
        return 4'b1111 >> idx;
    endfunction
endpackage

// File: rtl/jbl_shift.sv
module jbl_shift
    import jbl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic              shift,
    input  logic [WORD_W-1:0] cap_word,
    input  logic              tdi,
    output logic [WORD_W-1:0] sr_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (cap) begin
            sr_q <= cap_word;
        end else if (shift) begin
            sr_q <= {tdi, sr_q[WORD_W-1:1]};
        end
    end
endmodule

// File: rtl/jbl_fifo.sv
module jbl_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               push_data,
    input  logic                       pop,
    output logic [W-1:0]               head,
    output logic                       full,
    output logic                       empty,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
    assign head  = mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mem[g] <= '0;
                end else if (push && int'(wr_ptr) == g) begin
                    mem[g] <= push_data;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/jbl_reader.sv
module jbl_reader
    import jbl_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cap,
    input  logic                          empty,
    input  logic [NONCE_BYTES*BYTE_W-1:0] head,
    output logic                          pop,
    output logic [WORD_W-1:0]             word,
    output logic [1:0]                    idx
);
    rd_state_e state_q, state_d;
    logic [BYTE_W-1:0] cur_byte;

    assign idx = state_q;
    assign cur_byte = head[BYTE_W*int'(state_q) +: BYTE_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RD_B0;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        pop     = 1'b0;
        word    = '0;
        if (cap && !empty) begin
            word = {1'b1, pos_code(state_q), cur_byte};
            unique case (state_q)
                RD_B0: state_d = RD_B1;
                RD_B1: state_d = RD_B2;
                RD_B2: state_d = RD_B3;
                RD_B3: begin
                    state_d = RD_B0;
                    pop     = 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/jbl_loader.sv
module jbl_loader
    import jbl_pkg::*;
#(
    parameter int JOB_BYTES = 44
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        upd,
    input  logic [WORD_W-1:0]           wr_word,
    output logic [JOB_BYTES*BYTE_W-1:0] job_data,
    output logic                        job_valid
);
    localparam int JW = JOB_BYTES * BYTE_W;
    localparam int PW = $clog2(JOB_BYTES + 1);

    ld_state_e state_q, state_d;
    logic [PW-1:0] ptr_q, ptr_d;
    logic          store;
    logic [PW-1:0] store_idx;
    logic          fire;
    logic          is_start, is_cont;

    assign is_start = upd && !wr_word[BYTE_W];
    assign is_cont  = upd &&  wr_word[BYTE_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        ptr_d     = ptr_q;
        store     = 1'b0;
        store_idx = ptr_q;
        fire      = 1'b0;
        if (is_start) begin
            state_d   = LD_FILL;
            store     = 1'b1;
            store_idx = '0;
            ptr_d     = PW'(1);
        end else if (is_cont) begin
            unique case (state_q)
                LD_IDLE: ;
                LD_FILL: begin
                    store = 1'b1;
                    ptr_d = ptr_q + 1'b1;
                    if (ptr_q == PW'(JOB_BYTES - 1)) begin
                        state_d = LD_DONE;
                        fire    = 1'b1;
                    end
                end
                LD_DONE: ;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q     <= '0;
            job_data  <= '0;
            job_valid <= 1'b0;
        end else begin
            ptr_q     <= ptr_d;
            job_valid <= fire;
            if (store) begin
                job_data[(JW - BYTE_W) - BYTE_W*int'(store_idx) +: BYTE_W] <= wr_word[BYTE_W-1:0];
            end
        end
    end
endmodule

// File: rtl/jtag_byte_link.sv
module jtag_byte_link
    import jbl_pkg::*;
#(
    parameter int QDEPTH    = 4,
    parameter int JOB_BYTES = 44
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sel,
    input  logic                        cap,
    input  logic                        shift,
    input  logic                        upd,
    input  logic                        tdi,
    output logic                        tdo,
    input  logic                        push_valid,
    input  logic [31:0]                 push_nonce,
    output logic                        push_ready,
    output logic [JOB_BYTES*8-1:0]      job_data,
    output logic                        job_valid
);
    localparam int NW = NONCE_BYTES * BYTE_W;
    localparam int CW = $clog2(QDEPTH + 1);

    logic              cap_g, shift_g, upd_g;
    logic [WORD_W-1:0] sr_q;
    logic [WORD_W-1:0] rd_word;
    logic              q_pop, q_full, q_empty;
    logic [NW-1:0]     q_head;
    logic [CW-1:0]     q_count;
    logic [1:0]        rd_idx;

    assign cap_g   = sel && cap;
    assign shift_g = sel && shift;
    assign upd_g   = sel && upd;
    assign tdo        = sr_q[0];
    assign push_ready = !q_full;

    jbl_shift u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap      (cap_g),
        .shift    (shift_g),
        .cap_word (rd_word),
        .tdi      (tdi),
        .sr_q     (sr_q)
    );

    jbl_fifo #(.DEPTH(QDEPTH), .W(NW)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push_valid && !q_full),
        .push_data (push_nonce),
        .pop       (q_pop),
        .head      (q_head),
        .full      (q_full),
        .empty     (q_empty),
        .count     (q_count)
    );

    jbl_reader u_reader (
        .clk   (clk),
        .rst_n (rst_n),
        .cap   (cap_g),
        .empty (q_empty),
        .head  (q_head),
        .pop   (q_pop),
        .word  (rd_word),
        .idx   (rd_idx)
    );

    jbl_loader #(.JOB_BYTES(JOB_BYTES)) u_loader (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd       (upd_g),
        .wr_word   (sr_q),
        .job_data  (job_data),
        .job_valid (job_valid)
    );
endmodule

// File: rtl/jbl_checker.sv
module jbl_checker #(
    parameter int QDEPTH = 4,
    parameter int JW     = 352
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        sel,
    input logic                        cap,
    input logic                        push_ready,
    input logic                        job_valid,
    input logic [JW-1:0]               job_data,
    input logic [12:0]                 sr_q,
    input logic                        q_empty,
    input logic [$clog2(QDEPTH+1)-1:0] q_count,
    input logic [1:0]                  rd_idx
);
    // R7: completion pulse lasts a single cycle
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        job_valid |=> !job_valid);

    // R5: queue occupancy never exceeds its depth
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        int'(q_count) <= QDEPTH);

    // R4: a nonce stays queued while its later bytes are pending
    a_r4_mid_nonce_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx != 2'd0) |-> !q_empty);

    // R2: capture from an empty queue yields the zero word
    a_r2_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && cap && q_empty) |=> (sr_q == 13'd0));

    // R10: job register is untouched while the instruction is not selected
    a_r10_desel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> $stable(job_data));

    // R5: ready drops only when the queue has filled
    a_r5_ready_full: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(push_ready) |-> (int'(q_count) == QDEPTH));
endmodule

bind jtag_byte_link jbl_checker #(.QDEPTH(QDEPTH), .JW(JOB_BYTES*8)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (sel),
    .cap        (cap),
    .push_ready (push_ready),
    .job_valid  (job_valid),
    .job_data   (job_data),
    .sr_q       (sr_q),
    .q_empty    (q_empty),
    .q_count    (q_count),
    .rd_idx     (rd_idx)
);

// File: tb/sim_jtag_byte_link.sv
`timescale 1ns/1ps
module sim_jtag_byte_link;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b1, cap = 1'b0, shift = 1'b0, upd = 1'b0, tdi = 1'b0;
    logic tdo;
    logic push_valid = 1'b0;
    logic [31:0] push_nonce = '0;
    logic push_ready;
    logic [351:0] job_data;
    logic job_valid;

    int n_chk = 0;
    int n_fail = 0;
    bit mon_on = 1'b0;
    bit exp_jv = 1'b0;
    bit finished = 1'b0;

    // behavioural reference model
    logic [31:0] mq[$];
    int midx = 0;
    int mjob[44];
    int mptr = 0;
    bit mfill = 1'b0;

    always #2 clk = ~clk;

    jtag_byte_link u0 (
        .clk(clk), .rst_n(rst_n), .sel(sel), .cap(cap), .shift(shift), .upd(upd),
        .tdi(tdi), .tdo(tdo), .push_valid(push_valid), .push_nonce(push_nonce),
        .push_ready(push_ready), .job_data(job_data), .job_valid(job_valid)
    );

    task automatic chk(input bit ok, input string req, input logic [351:0] act, input logic [351:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [351:0] model_job();
        logic [351:0] v = '0;
        for (int k = 0; k < 44; k++) v[351 - 8*k -: 8] = mjob[k][7:0];
        return v;
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (mon_on) begin
            chk(push_ready === (mq.size() < 4), "R5 push_ready", push_ready, mq.size() < 4);
            chk(job_valid === exp_jv, "R7 job_valid", job_valid, exp_jv);
            exp_jv = 1'b0;
        end
    end

    task automatic push(input logic [31:0] n);
        @(negedge clk);
        push_valid = 1'b1;
        push_nonce = n;
        @(posedge clk);
        if (mq.size() < 4) mq.push_back(n);
        #1 push_valid = 1'b0;
    endtask

    task automatic scan_read(input bit s, input string req);
        logic [12:0] w;
        logic [12:0] e;
        @(negedge clk);
        sel = s;
        cap = 1'b1;
        @(posedge clk);
        e = '0;
        if (s && mq.size() > 0) begin
            e = {1'b1, 4'b1111 >> midx, 8'((mq[0] >> (8*midx)) & 32'hFF)};
            midx++;
            if (midx == 4) begin
                void'(mq.pop_front());
                midx = 0;
            end
        end
        #1 cap = 1'b0;
        sel = 1'b1;
        for (int i = 0; i < 13; i++) begin
            @(negedge clk);
            w[i] = tdo;
            shift = 1'b1;
            tdi = 1'b0;
            @(posedge clk);
            #1 shift = 1'b0;
        end
        if (s) chk(w === e, req, w, e);
    endtask

    task automatic scan_write(input logic [12:0] w, input bit s);
        for (int i = 0; i < 13; i++) begin
            @(negedge clk);
            sel = s;
            shift = 1'b1;
            tdi = w[i];
            @(posedge clk);
            #1 shift = 1'b0;
        end
        @(negedge clk);
        upd = 1'b1;
        @(posedge clk);
        if (s) begin
            if (!w[8]) begin
                mjob[0] = w[7:0];
                mptr = 1;
                mfill = 1'b1;
            end else if (mfill) begin
                mjob[mptr] = w[7:0];
                mptr++;
                if (mptr == 44) begin
                    mfill = 1'b0;
                    exp_jv = 1'b1;
                end
            end
        end
        #1 upd = 1'b0;
        sel = 1'b1;
    endtask

    task automatic load_job(input int seed, input int nbytes);
        for (int k = 0; k < nbytes; k++) begin
            logic [12:0] w;
            w = {4'b0000, (k != 0), 8'((seed * 37 + k * 11 + 5) & 8'hFF)};
            scan_write(w, 1'b1);
        end
    endtask

    initial begin
        for (int k = 0; k < 44; k++) mjob[k] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset values
        chk(tdo === 1'b0, "R1 tdo", tdo, 0);
        chk(job_valid === 1'b0, "R1 job_valid", job_valid, 0);
        chk(job_data === '0, "R1 job_data", job_data, 0);
        chk(push_ready === 1'b1, "R1 push_ready", push_ready, 1);
        rst_n = 1'b1;
        mon_on = 1'b1;

        // R2: empty queue reads as zero
        scan_read(1'b1, "R2 empty capture");

        // R3/R4: one nonce, bytes least significant first with position codes
        push(32'hA1B2C3D4);
        for (int i = 0; i < 4; i++) scan_read(1'b1, "R3 nonce byte");
        scan_read(1'b1, "R4 drained after four bytes");

        // R5: five pushes into four slots, fifth dropped
        for (int i = 0; i < 5; i++) push(32'h11111111 * (i + 1) + 32'h0F0E0D0C);
        for (int i = 0; i < 16; i++) scan_read(1'b1, "R5 queued nonce order");
        scan_read(1'b1, "R5 dropped push not stored");

        // R9: continuation bytes before any start are ignored
        scan_write(13'h1AB, 1'b1);
        scan_write(13'h1CD, 1'b1);
        chk(job_data === model_job(), "R9 stray continuation", job_data, model_job());

        // R6/R7: full job plus trailer
        load_job(1, 44);
        chk(job_data === model_job(), "R6 job assembly", job_data, model_job());
        scan_write(13'h100, 1'b1);
        scan_write(13'h1EE, 1'b1);
        chk(job_data === model_job(), "R7 trailer ignored", job_data, model_job());

        // R8: restart mid-load
        load_job(2, 10);
        load_job(3, 44);
        chk(job_data === model_job(), "R8 restart", job_data, model_job());

        // R10: strobes ignored while deselected
        scan_write(13'h05A, 1'b0);
        chk(job_data === model_job(), "R10 write deselected", job_data, model_job());
        push(32'hDEADBEEF);
        scan_read(1'b0, "R10 read deselected");
        scan_read(1'b1, "R10 first byte still pending");
        for (int i = 0; i < 3; i++) scan_read(1'b1, "R3 remaining bytes");

        @(negedge clk);
        mon_on = 1'b0;
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule